// File: doc/BRIEF.md
# Dual-Lane Simultaneous-Sampling ADC Reader

This block is the host-side master for a serial converter that samples two channels at once and returns both results on two separate data lines. When the user side asks for a conversion, the block lowers chip select and runs a fixed burst of serial clocks. The early clocks only pace the conversion inside the converter. The later clocks shift out the two results, and the block captures them in parallel. It then raises chip select, presents both words with a one-cycle strobe, and keeps chip select high for a quiet interval before the next request can be taken.

The same request can also carry a control word and a calibration flag. The control word goes out on the serial data input during the burst, most significant bit first. The calibration flag makes the block drive a calibration line high for a timed interval, followed by a guard delay, before chip select goes low. All intervals are set by parameters: the system clock frequency, the number of system clocks per serial clock, and the nanosecond and microsecond limits. The block derives every counter from these.

Top module: `adcrd_dual_reader`

## Requirements
- R1: While reset is held and just after it is released, cs_no=1, sclk_o=1, cal_o=0, din_o=0, busy_o=0 and valid_o=0.
- R2: Each transaction produces exactly CONV_CLKS+DATA_W (default 19+14=33) falling edges of sclk_o while cs_no is low. sclk_o is high whenever cs_no is high.
- R3: While cs_no is low, every sclk_o low phase and every high phase between falling edges lasts CLK_DIV/2 system cycles. The first falling edge comes ceil(CS_SETUP_NS*CLK_MHZ/1000)+1 system cycles after cs_no falls.
- R4: dout_a_i and dout_b_i are ignored on falling edges 1 to CONV_CLKS. On falling edges CONV_CLKS+1 to CONV_CLKS+DATA_W each lane is sampled into a DATA_W-bit word, most significant bit first. On that last edge the sample is bit 0.
- R5: Both words appear on res_a_o and res_b_o together, with valid_o high for exactly one cycle. That cycle is the first cycle in which cs_no is high again, and busy_o is still high during it.
- R6: If wr_en_i is high with the accepted start, wr_data_i (CTRL_W bits) is driven on din_o MSB first, and bit CTRL_W-1-i is present at falling edge i+1. After the word, and in a transaction without wr_en_i, din_o is 0. din_o changes only when sclk_o rises or when cs_no changes, and it is 0 while cs_no is high.
- R7: If cal_i is high with the accepted start, cal_o goes high for exactly CLK_MHZ*CAL_HIGH_US cycles while cs_no stays high. cs_no then falls exactly CLK_MHZ*CAL_WAIT_US cycles after cal_o falls. Without cal_i, cal_o stays low.
- R8: After cs_no rises it stays high for at least ceil(QUIET_NS*CLK_MHZ/1000)+2 cycles. With start_i held high, the next transaction lowers cs_no exactly that many cycles later.
- R9: A start_i pulse while busy_o is high is ignored. It causes no extra transaction and no calibration pulse, and the current burst stays at its full length.
- R10: busy_o goes high in the cycle after start_i is accepted in idle. It stays high until the quiet interval ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request one transaction; taken only when idle |
| cal_i | input | 1 | With start_i: run a calibration pulse first |
| wr_en_i | input | 1 | With start_i: send wr_data_i on din_o |
| wr_data_i | input | CTRL_W | Control word to shift out |
| busy_o | output | 1 | Transaction in progress |
| valid_o | output | 1 | One-cycle strobe: results valid |
| res_a_o | output | DATA_W | Result captured from lane A |
| res_b_o | output | DATA_W | Result captured from lane B |
| cs_no | output | 1 | Converter chip select, active low |
| sclk_o | output | 1 | Serial clock, idles high |
| din_o | output | 1 | Serial control data to converter |
| cal_o | output | 1 | Calibration line |
| dout_a_i | input | 1 | Serial result lane A |
| dout_b_i | input | 1 | Serial result lane B |

## Verification
The bench builds the block with CLK_MHZ=200 and CLK_DIV=6. The serial clock then has three-cycle phases, so any off-by-one in phase length or setup shows up as a whole-cycle difference. Setting CAL_HIGH_US and CAL_WAIT_US to 1 gives 200-cycle calibration and guard windows, which the bench measures to the exact cycle within a short run. The bench keeps CTRL_W=12 and the default 19/14 split, so the control word ends well before the data clocks. A bench converter drives ones on both lanes during the conversion clocks, so a capture taken on the wrong edge corrupts a known result word.

// File: rtl/adcrd_pkg.sv
`timescale 1ns/1ps
package adcrd_pkg;

  localparam int LANES = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CAL_HIGH,
    ST_CAL_WAIT,
    ST_CS_SETUP,
    ST_CONVERT,
    ST_SHIFT,
    ST_DONE,
    ST_QUIET
  } state_e;

  // ceil(ns * mhz / 1000), at least one cycle
  function automatic int ns_cycles(int mhz, int ns);
    int c;
    c = (mhz * ns + 999) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max_of(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adcrd_sclk_gen.sv
`timescale 1ns/1ps
module adcrd_sclk_gen #(
  parameter int CLK_DIV = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic sclk_o,
  output logic fall_o,
  output logic rise_o
);
  localparam int HALF  = CLK_DIV / 2;
  localparam int CNT_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;

  logic [CNT_W-1:0] cnt_q;

  assign fall_o = run_i && (cnt_q == '0);
  assign rise_o = run_i && (cnt_q == CNT_W'(HALF));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!run_i || cnt_q == CNT_W'(CLK_DIV - 1)) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sclk_o <= 1'b1;
    else if (!run_i)  sclk_o <= 1'b1;
    else if (fall_o)  sclk_o <= 1'b0;
    else if (rise_o)  sclk_o <= 1'b1;
  end

endmodule

// File: rtl/adcrd_lane.sv
`timescale 1ns/1ps
module adcrd_lane #(
  parameter int W = 14
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (en_i) q_o <= {q_o[W-2:0], d_i};
  end
endmodule

// File: rtl/adcrd_din_shift.sv
`timescale 1ns/1ps
module adcrd_din_shift #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  input  logic         shift_i,
  output logic         msb_o
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (load_i)  sr_q <= data_i;
    else if (shift_i) sr_q <= {sr_q[W-2:0], 1'b0};
  end

  assign msb_o = sr_q[W-1];
endmodule

// File: rtl/adcrd_dual_reader.sv
`timescale 1ns/1ps
module adcrd_dual_reader
  import adcrd_pkg::*;
#(
  parameter int CLK_MHZ     = 200,
  parameter int CLK_DIV     = 8,
  parameter int DATA_W      = 14,
  parameter int CONV_CLKS   = 19,
  parameter int CTRL_W      = 12,
  parameter int CAL_HIGH_US = 2,
  parameter int CAL_WAIT_US = 2,
  parameter int QUIET_NS    = 13,
  parameter int CS_SETUP_NS = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              cal_i,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  output logic              busy_o,
  output logic              valid_o,
  output logic [DATA_W-1:0] res_a_o,
  output logic [DATA_W-1:0] res_b_o,
  output logic              cs_no,
  output logic              sclk_o,
  output logic              din_o,
  output logic              cal_o,
  input  logic              dout_a_i,
  input  logic              dout_b_i
);
  localparam int FRAME_CLKS   = CONV_CLKS + DATA_W;
  localparam int CAL_HIGH_CYC = CLK_MHZ * CAL_HIGH_US;
  localparam int CAL_WAIT_CYC = CLK_MHZ * CAL_WAIT_US;
  localparam int QUIET_CYC    = ns_cycles(CLK_MHZ, QUIET_NS);
  localparam int SETUP_CYC    = ns_cycles(CLK_MHZ, CS_SETUP_NS);
  localparam int TMR_MAX      = max_of(max_of(CAL_HIGH_CYC, CAL_WAIT_CYC),
                                       max_of(QUIET_CYC, SETUP_CYC));
  localparam int TMR_W        = $clog2(TMR_MAX + 1);
  localparam int FCNT_W       = $clog2(FRAME_CLKS + 1);

  state_e              state_q, state_d;
  logic [TMR_W-1:0]    tmr_q, tmr_d;
  logic [FCNT_W-1:0]   fcnt_q, fcnt_d;
  logic                run, fall_tick, rise_tick;
  logic                capture_en, frame_end, din_load, din_msb;
  logic [LANES-1:0]    lane_d;
  logic [DATA_W-1:0]   lane_q [LANES];

  assign run = (state_q == ST_CONVERT) || (state_q == ST_SHIFT);

  adcrd_sclk_gen #(.CLK_DIV(CLK_DIV)) u_sclk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .sclk_o (sclk_o),
    .fall_o (fall_tick),
    .rise_o (rise_tick)
  );

  // only falls after the conversion clocks shift data in
  assign capture_en = fall_tick && (state_q == ST_SHIFT);
  assign frame_end  = (state_q == ST_SHIFT) && rise_tick
                      && (fcnt_q == FCNT_W'(FRAME_CLKS));
  assign lane_d     = {dout_b_i, dout_a_i};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    adcrd_lane #(.W(DATA_W)) u_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (capture_en),
      .d_i    (lane_d[g]),
      .q_o    (lane_q[g])
    );
  end

  assign din_load = (state_q == ST_IDLE) && start_i;

  adcrd_din_shift #(.W(CTRL_W)) u_din (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (din_load),
    .data_i  (wr_en_i ? wr_data_i : '0),
    .shift_i (rise_tick),
    .msb_o   (din_msb)
  );

  always_comb begin
    state_d = state_q;
    tmr_d   = tmr_q;
    fcnt_d  = fcnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          if (cal_i) begin
            state_d = ST_CAL_HIGH;
            tmr_d   = TMR_W'(CAL_HIGH_CYC - 1);
          end else begin
            state_d = ST_CS_SETUP;
            tmr_d   = TMR_W'(SETUP_CYC - 1);
          end
        end
      end
      ST_CAL_HIGH: begin
        tmr_d = tmr_q - 1'b1;
        if (tmr_q == '0) begin
          state_d = ST_CAL_WAIT;
          tmr_d   = TMR_W'(CAL_WAIT_CYC - 1);
        end
      end
      ST_CAL_WAIT: begin
        tmr_d = tmr_q - 1'b1;
        if (tmr_q == '0) begin
          state_d = ST_CS_SETUP;
          tmr_d   = TMR_W'(SETUP_CYC - 1);
        end
      end
      ST_CS_SETUP: begin
        tmr_d = tmr_q - 1'b1;
        if (tmr_q == '0) begin
          state_d = ST_CONVERT;
          fcnt_d  = '0;
        end
      end
      ST_CONVERT: begin
        if (fall_tick) begin
          fcnt_d = fcnt_q + 1'b1;
          if (fcnt_q == FCNT_W'(CONV_CLKS - 1)) state_d = ST_SHIFT;
        end
      end
      ST_SHIFT: begin
        if (fall_tick) fcnt_d = fcnt_q + 1'b1;
        if (frame_end) state_d = ST_DONE;
      end
      ST_DONE: begin
        state_d = ST_QUIET;
        tmr_d   = TMR_W'(QUIET_CYC - 1);
      end
      ST_QUIET: begin
        tmr_d = tmr_q - 1'b1;
        if (tmr_q == '0) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tmr_q   <= '0;
      fcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      tmr_q   <= tmr_d;
      fcnt_q  <= fcnt_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_a_o <= '0;
      res_b_o <= '0;
    end else if (frame_end) begin
      res_a_o <= lane_q[0];
      res_b_o <= lane_q[1];
    end
  end

  assign cs_no   = !((state_q == ST_CS_SETUP) || run);
  assign cal_o   = (state_q == ST_CAL_HIGH);
  assign busy_o  = (state_q != ST_IDLE);
  assign valid_o = (state_q == ST_DONE);
  assign din_o   = !cs_no && din_msb;

endmodule

// File: rtl/adcrd_dual_reader_chk.sv
`timescale 1ns/1ps
module adcrd_dual_reader_chk #(
  parameter int FRAME_CLKS = 33
) (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic busy_o,
  input logic valid_o,
  input logic cs_no,
  input logic sclk_o,
  input logic din_o,
  input logic cal_o
);
  localparam int FW = $clog2(FRAME_CLKS + 2);

  logic          sclk_q;
  logic [FW-1:0] falls_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q  <= 1'b1;
      falls_q <= '0;
    end else begin
      sclk_q <= sclk_o;
      if (cs_no)                 falls_q <= '0;
      else if (sclk_q && !sclk_o) falls_q <= falls_q + 1'b1;
    end
  end

  assert_sclk_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> sclk_o);

  assert_frame_len_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |-> (falls_q == FW'(FRAME_CLKS)));

  assert_valid_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  assert_valid_cs_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (cs_no && busy_o));

  assert_din_at_fall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sclk_o) |-> $stable(din_o));

  assert_din_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !din_o);

  assert_cal_cs_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_o |-> (cs_no && busy_o));

  assert_busy_start_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

endmodule

bind adcrd_dual_reader adcrd_dual_reader_chk #(.FRAME_CLKS(FRAME_CLKS)) u_chk (.*);

// File: tb/adcrd_dual_reader_tb.sv
`timescale 1ns/1ps
module adcrd_dual_reader_tb;
  localparam int CLK_MHZ   = 200;
  localparam int CLK_DIV   = 6;
  localparam int HALF      = CLK_DIV / 2;
  localparam int DATA_W    = 14;
  localparam int CONV      = 19;
  localparam int FRAME     = CONV + DATA_W;
  localparam int CTRL_W    = 12;
  localparam int CAL_US    = 1;
  localparam int WAIT_US   = 1;
  localparam int CAL_CYC   = CLK_MHZ * CAL_US;
  localparam int WAIT_CYC  = CLK_MHZ * WAIT_US;
  localparam int QUIET_CYC = (13 * CLK_MHZ + 999) / 1000;
  localparam int SETUP_CYC = (10 * CLK_MHZ + 999) / 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, cal = 1'b0, wr_en = 1'b0;
  logic [CTRL_W-1:0] wr_data = '0;
  logic busy, valid, cs_no, sclk, din, cal_o;
  logic [DATA_W-1:0] res_a, res_b;
  logic dout_a = 1'b1, dout_b = 1'b1;

  always #2.5 clk = ~clk;

  adcrd_dual_reader #(
    .CLK_MHZ(CLK_MHZ), .CLK_DIV(CLK_DIV), .DATA_W(DATA_W), .CONV_CLKS(CONV),
    .CTRL_W(CTRL_W), .CAL_HIGH_US(CAL_US), .CAL_WAIT_US(WAIT_US),
    .QUIET_NS(13), .CS_SETUP_NS(10)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cal_i(cal), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .busy_o(busy), .valid_o(valid), .res_a_o(res_a),
    .res_b_o(res_b), .cs_no(cs_no), .sclk_o(sclk), .din_o(din), .cal_o(cal_o),
    .dout_a_i(dout_a), .dout_b_i(dout_b)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // monitor / converter model state
  logic [DATA_W-1:0] pat_a = '0, pat_b = '0;
  logic [FRAME-1:0]  din_cap;
  logic [DATA_W-1:0] got_a, got_b;
  int frames = 0, falls = 0, run = 0, tim_bad = 0, sclk_bad = 0;
  int cs_low = 0, cs_hi = 0, quiet_len = 0, setup_len = 0;
  int cal_len = 0, gap = 0, cal_gap = 0, valid_cnt = 0, valid_cs_bad = 0;
  bit cal_gap_on = 0, have_rise = 0;
  logic sclk_p = 1'b1, cs_p = 1'b1, cal_p = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (cs_no && !sclk) sclk_bad++;
      if (sclk != sclk_p) begin
        if (!cs_p) begin
          if (!sclk) begin
            if (falls == 0) setup_len = cs_low;
            else if (run != HALF) tim_bad++;
            falls++;
            din_cap = {din_cap[FRAME-2:0], din};
            if (falls >= CONV && falls < FRAME) begin
              dout_a = pat_a[DATA_W-1-(falls-CONV)];
              dout_b = pat_b[DATA_W-1-(falls-CONV)];
            end else begin
              dout_a = 1'b1;
              dout_b = 1'b1;
            end
          end else if (run != HALF) tim_bad++;
        end
        run = 1;
      end else run++;
      if (cs_p && !cs_no) begin
        frames++;
        if (have_rise) quiet_len = cs_hi;
        if (cal_gap_on) begin cal_gap = gap; cal_gap_on = 0; end
        falls = 0; din_cap = '0; cs_low = 1; tim_bad = 0;
      end else if (!cs_no) cs_low++;
      if (!cs_p && cs_no) begin have_rise = 1; cs_hi = 1; end
      else if (cs_no) cs_hi++;
      if (cal_gap_on) gap++;
      if (cal_o) cal_len++;
      if (cal_p && !cal_o) begin cal_gap_on = 1; gap = 1; end
      if (valid) begin
        valid_cnt++;
        if (!cs_no) valid_cs_bad++;
        got_a = res_a; got_b = res_b;
      end
      sclk_p = sclk; cs_p = cs_no; cal_p = cal_o;
    end
  end

  task automatic pulse_start(input bit c, input bit w, input logic [CTRL_W-1:0] d);
    @(negedge clk);
    start = 1'b1; cal = c; wr_en = w; wr_data = d;
    @(negedge clk);
    start = 1'b0; cal = 1'b0; wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic check_frame(input string tag, input bit w, input logic [CTRL_W-1:0] d);
    logic [FRAME-1:0] exp_din;
    exp_din = w ? {d, {(FRAME-CTRL_W){1'b0}}} : '0;
    chk(falls == FRAME, {tag, " R2 falls"}, falls, FRAME);
    chk(sclk_bad == 0, {tag, " R2 sclk idle"}, sclk_bad, 0);
    chk(tim_bad == 0, {tag, " R3 phases"}, tim_bad, 0);
    chk(setup_len == SETUP_CYC + 1, {tag, " R3 setup"}, setup_len, SETUP_CYC + 1);
    chk(got_a == pat_a, {tag, " R4 lane a"}, got_a, pat_a);
    chk(got_b == pat_b, {tag, " R4 lane b"}, got_b, pat_b);
    chk(valid_cs_bad == 0, {tag, " R5 valid cs"}, valid_cs_bad, 0);
    chk(din_cap == exp_din, {tag, " R6 din"}, din_cap, exp_din);
  endtask

  task automatic run_frame(input string tag, input bit c, input bit w,
                           input logic [CTRL_W-1:0] d,
                           input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b);
    int v0;
    pat_a = a; pat_b = b;
    cal_len = 0; v0 = valid_cnt;
    pulse_start(c, w, d);
    chk(busy == 1'b1, {tag, " R10 busy rise"}, busy, 1);
    wait (valid_cnt == v0 + 1);
    wait (!busy);
    @(negedge clk);
    chk(valid_cnt == v0 + 1, {tag, " R5 one valid"}, valid_cnt - v0, 1);
    check_frame(tag, w, d);
    if (c) begin
      chk(cal_len == CAL_CYC, {tag, " R7 cal high"}, cal_len, CAL_CYC);
      chk(cal_gap == WAIT_CYC, {tag, " R7 cal guard"}, cal_gap, WAIT_CYC);
    end else begin
      chk(cal_len == 0, {tag, " R7 no cal"}, cal_len, 0);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk({cs_no, sclk, cal_o, din, busy, valid} == 6'b110000, "R1 in reset",
        {cs_no, sclk, cal_o, din, busy, valid}, 6'b110000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({cs_no, sclk, cal_o, din, busy, valid} == 6'b110000, "R1 after reset",
        {cs_no, sclk, cal_o, din, busy, valid}, 6'b110000);
  endtask

  task automatic t_back_to_back();
    int f0, v0;
    pat_a = 14'h1234; pat_b = 14'h0ACE;
    f0 = frames; v0 = valid_cnt;
    @(negedge clk);
    start = 1'b1;
    wait (frames == f0 + 2);
    @(negedge clk);
    start = 1'b0;
    wait (valid_cnt == v0 + 2);
    wait (!busy);
    @(negedge clk);
    chk(quiet_len == QUIET_CYC + 2, "R8 quiet gap", quiet_len, QUIET_CYC + 2);
    check_frame("b2b", 1'b0, '0);
  endtask

  task automatic t_ignore_busy();
    int f0, v0;
    pat_a = 14'h2DB6; pat_b = 14'h1249;
    f0 = frames; v0 = valid_cnt; cal_len = 0;
    pulse_start(1'b0, 1'b0, '0);
    wait (!cs_no);
    repeat (40) @(negedge clk);
    pulse_start(1'b1, 1'b1, 12'hFFF);
    wait (valid_cnt == v0 + 1);
    wait (!busy);
    repeat (30) @(negedge clk);
    chk(frames == f0 + 1, "R9 no extra frame", frames - f0, 1);
    chk(cal_len == 0, "R9 no cal pulse", cal_len, 0);
    chk(cs_no == 1'b1 && busy == 1'b0, "R9 stays idle", {cs_no, busy}, 2'b10);
    check_frame("ignore", 1'b0, '0);
  endtask

  initial begin
    t_reset();
    run_frame("plain", 1'b0, 1'b0, '0, 14'h2A5C, 14'h15A3);
    run_frame("write", 1'b0, 1'b1, 12'hA5F, 14'h3FFF, 14'h0000);
    run_frame("cal", 1'b1, 1'b1, 12'h3C1, 14'h0001, 14'h2000);
    t_back_to_back();
    t_ignore_busy();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule